// File: doc/BRIEF.md
# Hot-Plug Slot Register Block

This block holds the control and status state for one hot-pluggable expansion slot. Software reaches it through a small 16-bit register port with four word addresses. Two of them return a fixed 32-bit capability word built from parameters, one holds the slot control word, and one holds the slot status word. Reads are combinational from the address. A write is accepted on any rising clock edge where the write enable is high.

On the slot side the block takes already-debounced levels for the attention button, adapter presence, the retention-latch sensor, power fault and the interlock state. It drives the slot power enable, the two indicator fields and a one-cycle interlock toggle pulse. It latches edge events into the status word, where software clears them by writing ones. Every write to the control word is a command, and a fixed number of cycles later the block reports it complete. It drives one level interrupt while any enabled event is pending.

Top module: `hpslot_regs`

## Requirements
- R1: After reset the control word reads 0x07C0, meaning slot power is off and both indicator fields are 11 (off). Status bits 4:0 read 0, `irq` is 0 and `slot_pwr_en` is 0.
- R2: Address 0 returns capability bits 15:0 and address 1 returns capability bits 31:16. Capability bits 0..6 are button, power controller, latch sensor, attention indicator, power indicator, surprise removal and hot-plug capable. Bit 17 means an interlock is present, bit 18 means completion is not reported, and bits 31:19 hold the slot number. Writes to these addresses change nothing.
- R3: A write to address 2 stores bits 10:0. The new value is visible from the cycle after the write edge: `attn_ind` = bits 7:6, `pwr_ind` = bits 9:8 (01 on, 10 blink, 11 off, 00 reserved), and `slot_pwr_en` = NOT bit 10. Bit 11 always reads 0.
- R4: A control write with bit 11 set makes `ilock_toggle` high for exactly the one cycle after the write edge. That bit is not stored.
- R5: Status bit 4 (command completed) sets exactly CMPL_DELAY rising edges after the edge that accepted a control write. A later write restarts the count.
- R6: If completion is flagged unsupported, or if none of power controller, the two indicators or interlock is present, status bit 4 never sets.
- R7: Status bit 3 (presence changed) and bit 2 (latch changed) set on either edge of their inputs. Bit 0 (button) and bit 1 (power fault) set only on a rising edge. Each sets on the edge that first samples the new level. No event is taken on the first edge after reset.
- R8: Writing address 3 clears each status bit 4:0 written as 1 and leaves bits written as 0 unchanged. An event arriving on the same edge wins over the clear.
- R9: The power-fault status bit (bit 1) cannot be cleared while control bit 10 is 1 (power off).
- R10: Status bits 7:5 show the live latch, presence and interlock input levels. Bits 15:8 read 0.
- R11: `irq` is high exactly when control bit 5 is set and either some status bit among 3:0 is set with its matching control bit, or status bit 4 and control bit 4 are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Word address: 0/1 capability, 2 control, 3 status |
| reg_wr_en | input | 1 | Write strobe, sampled on the rising edge |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` (combinational) |
| btn_in | input | 1 | Attention button level |
| present_in | input | 1 | Adapter presence level |
| latch_in | input | 1 | Retention-latch sensor level |
| pfault_in | input | 1 | Power fault level |
| ilock_state_in | input | 1 | Interlock engaged level |
| slot_pwr_en | output | 1 | Slot power enable |
| attn_ind | output | 2 | Attention indicator state |
| pwr_ind | output | 2 | Power indicator state |
| ilock_toggle | output | 1 | One-cycle interlock toggle request |
| irq | output | 1 | Level interrupt |

## Verification
Control outputs and the toggle pulse change one edge after a control write. Input edges appear in the status word after the first edge that samples them. Completion appears CMPL_DELAY edges after the accepting write. The interrupt follows the registered state with no further delay. The bench keeps a behavioural model that advances on each rising edge from the same sampled inputs, and compares every output at the falling edge. It drives stimulus shortly after that falling edge, so each result is checked in the cycle it is due. Directed checks around completion count negative edges from the write so that they sample on the last cycle before the bit sets and on the first cycle after.

// File: rtl/hpslot_pkg.sv
package hpslot_pkg;
   localparam int REG_W  = 16;
   localparam int N_LVL  = 4;
   localparam int CTRL_W = 11;

   typedef enum logic [1:0] {
      A_CAP_LO = 2'd0,
      A_CAP_HI = 2'd1,
      A_CTRL   = 2'd2,
      A_STAT   = 2'd3
   } hp_addr_e;

   // status / enable bit positions (decoded by software)
   localparam int B_BTN   = 0;
   localparam int B_PF    = 1;
   localparam int B_LATCH = 2;
   localparam int B_PRES  = 3;
   localparam int B_CMPL  = 4;
   localparam int B_HP_IE = 5;
   localparam int B_ATTN  = 6;
   localparam int B_PIND  = 8;
   localparam int B_POFF  = 10;
   localparam int B_ILOCK = 11;

   localparam logic [CTRL_W-1:0] CTRL_RST = 11'h7C0;
endpackage

// File: rtl/hpslot_ctrl.sv
module hpslot_ctrl
   import hpslot_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic [CTRL_W:0]   wdata_i,
   output logic [CTRL_W-1:0] ctrl_o,
   output logic              tog_o
);
   logic [CTRL_W-1:0] ctrl_q;
   logic              tog_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= CTRL_RST;
         tog_q  <= 1'b0;
      end else begin
         tog_q <= wr_i & wdata_i[B_ILOCK];
         if (wr_i) ctrl_q <= wdata_i[CTRL_W-1:0];
      end
   end

   assign ctrl_o = ctrl_q;
   assign tog_o  = tog_q;

   // R3
   ctrl_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_i |=> ctrl_o == $past(wdata_i[CTRL_W-1:0]));
   // R4
   tog_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tog_o |-> $past(wr_i && wdata_i[B_ILOCK]));
endmodule

// File: rtl/hpslot_cmpl.sv
module hpslot_cmpl #(
   parameter int DELAY  = 64,
   parameter bit ENABLE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic done_o
);
   localparam int CW = $clog2(DELAY + 1);

   generate
      if (DELAY < 1) begin : g_bad_delay
         $error("hpslot_cmpl: DELAY must be at least 1");
      end

      if (ENABLE) begin : g_timer
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                cnt_q <= '0;
            else if (start_i)          cnt_q <= CW'(DELAY);
            else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
         end
         assign done_o = (cnt_q == CW'(1));

         if (DELAY > 1) begin : g_min_gap
            // R5
            no_early_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
               start_i |=> !done_o);
         end
      end else begin : g_none
         logic unused_start;
         assign unused_start = start_i;
         assign done_o       = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/hpslot_evt.sv
module hpslot_evt #(
   parameter int               NL        = 4,
   parameter logic [NL-1:0]    BOTH_EDGE = '0,
   parameter logic [NL:0]      STICKY    = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [NL-1:0] lvl_i,
   input  logic          cmpl_i,
   input  logic          clr_i,
   input  logic [NL:0]   clr_mask_i,
   input  logic          pwr_on_i,
   output logic [NL:0]   stat_o
);
   logic [NL-1:0] prev_q;
   logic [NL-1:0] ev;
   logic [NL:0]   clr_eff;
   logic [NL:0]   stat_q;
   logic          primed_q;

   generate
      for (genvar i = 0; i < NL; i++) begin : g_edge
         if (BOTH_EDGE[i]) begin : g_both
            assign ev[i] = primed_q & (lvl_i[i] ^ prev_q[i]);
         end else begin : g_rise
            assign ev[i] = primed_q & lvl_i[i] & ~prev_q[i];
         end
      end
      for (genvar j = 0; j <= NL; j++) begin : g_clr
         if (STICKY[j]) begin : g_hold
            assign clr_eff[j] = clr_i & clr_mask_i[j] & pwr_on_i;
         end else begin : g_free
            assign clr_eff[j] = clr_i & clr_mask_i[j];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q   <= '0;
         primed_q <= 1'b0;
         stat_q   <= '0;
      end else begin
         prev_q   <= lvl_i;
         primed_q <= 1'b1;
         stat_q   <= (stat_q & ~clr_eff) | {cmpl_i, ev};
      end
   end

   assign stat_o = stat_q;

   // R7
   rise_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (primed_q && lvl_i[0] && !prev_q[0]) |=> stat_o[0]);
   // R7
   fall_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (primed_q && !lvl_i[NL-1] && prev_q[NL-1] && BOTH_EDGE[NL-1]) |=> stat_o[NL-1]);
   // R8
   w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && clr_mask_i[0] && !ev[0]) |=> !stat_o[0]);
   // R9
   sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_o[1] && !pwr_on_i && STICKY[1]) |=> stat_o[1]);
endmodule

// File: rtl/hpslot_regs.sv
module hpslot_regs
   import hpslot_pkg::*;
#(
   parameter int CMPL_DELAY   = 64,
   parameter int SLOT_NUM     = 1,
   parameter bit HAS_BUTTON   = 1'b1,
   parameter bit HAS_PWRCTL   = 1'b1,
   parameter bit HAS_LATCH    = 1'b1,
   parameter bit HAS_ATTN_IND = 1'b1,
   parameter bit HAS_PWR_IND  = 1'b1,
   parameter bit SURPRISE_OK  = 1'b0,
   parameter bit HOTPLUG_OK   = 1'b1,
   parameter bit HAS_ILOCK    = 1'b1,
   parameter bit NO_CMPL      = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        reg_addr,
   input  logic              reg_wr_en,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  reg_rdata,
   input  logic              btn_in,
   input  logic              present_in,
   input  logic              latch_in,
   input  logic              pfault_in,
   input  logic              ilock_state_in,
   output logic              slot_pwr_en,
   output logic [1:0]        attn_ind,
   output logic [1:0]        pwr_ind,
   output logic              ilock_toggle,
   output logic              irq
);
   localparam logic [12:0] SLOT_BITS = 13'(SLOT_NUM);
   localparam logic [31:0] CAP_WORD  = {SLOT_BITS, NO_CMPL, HAS_ILOCK, 10'b0,
                                        HOTPLUG_OK, SURPRISE_OK, HAS_PWR_IND,
                                        HAS_ATTN_IND, HAS_LATCH, HAS_PWRCTL, HAS_BUTTON};
   localparam bit CMPL_OK = !NO_CMPL &&
                            (HAS_PWRCTL || HAS_ATTN_IND || HAS_PWR_IND || HAS_ILOCK);
   // presence and latch take both edges; power fault is sticky
   localparam logic [N_LVL-1:0] BOTH_MASK = 4'b1100;
   localparam logic [N_LVL:0]   STICKY    = 5'b00010;

   generate
      if (SLOT_NUM < 0 || SLOT_NUM > 8191) begin : g_bad_slot
         $error("hpslot_regs: SLOT_NUM must fit in 13 bits");
      end
   endgenerate

   hp_addr_e          addr;
   logic              ctl_wr, st_wr, cmpl_evt;
   logic [CTRL_W-1:0] ctrl;
   logic [N_LVL:0]    stat;
   logic [N_LVL-1:0]  lvl;
   logic              unused_wdata_hi;

   assign addr            = hp_addr_e'(reg_addr);
   assign ctl_wr          = reg_wr_en && (addr == A_CTRL);
   assign st_wr           = reg_wr_en && (addr == A_STAT);
   assign lvl             = {present_in, latch_in, pfault_in, btn_in};
   assign unused_wdata_hi = ^reg_wdata[REG_W-1:CTRL_W+1];

   hpslot_ctrl u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_i    (ctl_wr),
      .wdata_i (reg_wdata[CTRL_W:0]),
      .ctrl_o  (ctrl),
      .tog_o   (ilock_toggle)
   );

   hpslot_cmpl #(.DELAY(CMPL_DELAY), .ENABLE(CMPL_OK)) u_cmpl (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (ctl_wr),
      .done_o  (cmpl_evt)
   );

   hpslot_evt #(.NL(N_LVL), .BOTH_EDGE(BOTH_MASK), .STICKY(STICKY)) u_evt (
      .clk        (clk),
      .rst_n      (rst_n),
      .lvl_i      (lvl),
      .cmpl_i     (cmpl_evt),
      .clr_i      (st_wr),
      .clr_mask_i (reg_wdata[N_LVL:0]),
      .pwr_on_i   (!ctrl[B_POFF]),
      .stat_o     (stat)
   );

   assign slot_pwr_en = !ctrl[B_POFF];
   assign attn_ind    = ctrl[B_ATTN+1:B_ATTN];
   assign pwr_ind     = ctrl[B_PIND+1:B_PIND];
   assign irq         = ctrl[B_HP_IE] &&
                        ((|(stat[N_LVL-1:0] & ctrl[N_LVL-1:0])) ||
                         (stat[B_CMPL] && ctrl[B_CMPL]));

   always_comb begin
      unique case (addr)
         A_CAP_LO: reg_rdata = CAP_WORD[15:0];
         A_CAP_HI: reg_rdata = CAP_WORD[31:16];
         A_CTRL:   reg_rdata = {5'b0, ctrl};
         default:  reg_rdata = {8'b0, ilock_state_in, present_in, latch_in, stat};
      endcase
   end

   // R11
   irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl[B_HP_IE] |-> !irq);
   // R10
   live_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (addr == A_STAT) |-> reg_rdata[7:5] == {ilock_state_in, present_in, latch_in});

   generate
      if (!CMPL_OK) begin : g_no_cmpl_chk
         // R6
         never_cmpl_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !stat[B_CMPL]);
      end
   endgenerate
endmodule

// File: tb/hpslot_regs_bench.sv
module hpslot_regs_bench;
   localparam int DLY = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  reg_addr = 2'd0;
   logic        reg_wr_en = 1'b0;
   logic [15:0] reg_wdata = 16'h0;
   logic        btn_in = 0, present_in = 0, latch_in = 0, pfault_in = 0, ilock_state_in = 0;
   logic [15:0] reg_rdata, nc_rdata;
   logic        slot_pwr_en, ilock_toggle, irq;
   logic [1:0]  attn_ind, pwr_ind;
   logic        nc_pwr, nc_tog, nc_irq;
   logic [1:0]  nc_attn, nc_pind;

   int checks = 0, errs = 0, tog_count = 0;
   bit started = 0;

   always #10 clk = ~clk;

   hpslot_regs #(.CMPL_DELAY(DLY), .SLOT_NUM(37)) u_hpslot_regs (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr_en(reg_wr_en),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .btn_in(btn_in),
      .present_in(present_in), .latch_in(latch_in), .pfault_in(pfault_in),
      .ilock_state_in(ilock_state_in), .slot_pwr_en(slot_pwr_en),
      .attn_ind(attn_ind), .pwr_ind(pwr_ind), .ilock_toggle(ilock_toggle), .irq(irq));

   hpslot_regs #(.CMPL_DELAY(DLY), .HAS_PWRCTL(1'b0), .HAS_ATTN_IND(1'b0),
                 .HAS_PWR_IND(1'b0), .HAS_ILOCK(1'b0)) u_hpslot_regs_nc (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr_en(reg_wr_en),
      .reg_wdata(reg_wdata), .reg_rdata(nc_rdata), .btn_in(btn_in),
      .present_in(present_in), .latch_in(latch_in), .pfault_in(pfault_in),
      .ilock_state_in(ilock_state_in), .slot_pwr_en(nc_pwr),
      .attn_ind(nc_attn), .pwr_ind(nc_pind), .ilock_toggle(nc_tog), .irq(nc_irq));

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // behavioural reference model, advanced on every rising edge
   logic [15:0] m_ctrl;
   logic [4:0]  m_st;
   logic [3:0]  m_prev;
   int          m_cnt;
   bit          m_primed, m_tog;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_ctrl = 16'h07C0; m_st = '0; m_prev = '0; m_cnt = 0; m_primed = 0; m_tog = 0;
      end else begin
         logic [3:0] lv, ev;
         logic [4:0] clr;
         bit ce;
         lv = {present_in, latch_in, pfault_in, btn_in};
         ev = '0;
         if (m_primed) begin
            ev[0] = lv[0] & ~m_prev[0];
            ev[1] = lv[1] & ~m_prev[1];
            ev[2] = lv[2] ^ m_prev[2];
            ev[3] = lv[3] ^ m_prev[3];
         end
         ce  = (m_cnt == 1);
         clr = (reg_wr_en && reg_addr == 2'd3) ? reg_wdata[4:0] : 5'b0;
         if (m_ctrl[10]) clr[1] = 1'b0;
         m_st = (m_st & ~clr) | {ce, ev};
         if (reg_wr_en && reg_addr == 2'd2) begin
            m_cnt  = DLY;
            m_ctrl = reg_wdata & 16'h07FF;
            m_tog  = reg_wdata[11];
         end else begin
            if (m_cnt > 0) m_cnt--;
            m_tog = 0;
         end
         m_prev = lv;
         m_primed = 1;
      end
   end

   always @(negedge clk) begin
      if (started && rst_n) begin
         logic [15:0] exp_rd;
         bit exp_irq;
         exp_irq = m_ctrl[5] && ((|(m_st[3:0] & m_ctrl[3:0])) || (m_st[4] && m_ctrl[4]));
         case (reg_addr)
            2'd0: exp_rd = 16'h005F;
            2'd1: exp_rd = 16'h012A;
            2'd2: exp_rd = m_ctrl;
            default: exp_rd = {8'h00, ilock_state_in, present_in, latch_in, m_st};
         endcase
         chk(reg_rdata === exp_rd, (reg_addr < 2) ? "R2 cap" : (reg_addr == 2 ? "R3 ctrl" : "R8 status"),
             32'(reg_rdata), 32'(exp_rd));
         chk({slot_pwr_en, pwr_ind, attn_ind} === {!m_ctrl[10], m_ctrl[9:8], m_ctrl[7:6]},
             "R3 outputs", 32'({slot_pwr_en, pwr_ind, attn_ind}),
             32'({!m_ctrl[10], m_ctrl[9:8], m_ctrl[7:6]}));
         chk(ilock_toggle === m_tog, "R4 toggle", 32'(ilock_toggle), 32'(m_tog));
         chk(irq === exp_irq, "R11 irq", 32'(irq), 32'(exp_irq));
         if (reg_addr == 2'd3)
            chk(nc_rdata[4] === 1'b0, "R6 no completion", 32'(nc_rdata[4]), 32'h0);
         if (ilock_toggle) tog_count++;
      end
   end

   task automatic step(input int n);
      repeat (n) begin @(negedge clk); #2; end
   endtask

   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      reg_addr = a; reg_wdata = d; reg_wr_en = 1'b1;
      @(negedge clk); #2;
      reg_wr_en = 1'b0;
   endtask

   task automatic look(input logic [1:0] a);
      reg_addr = a;
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      #2 rst_n = 1'b1;
      started = 1;
      // R1 reset state
      look(2'd2); chk(reg_rdata == 16'h07C0, "R1 ctrl reset", 32'(reg_rdata), 32'h07C0); #2;
      look(2'd3); chk(reg_rdata[4:0] == 5'b0 && !irq && !slot_pwr_en && attn_ind == 2'b11,
                      "R1 status/outputs", 32'({reg_rdata[4:0], irq, slot_pwr_en, attn_ind}), 32'h3); #2;
      // R2 capability is read-only
      wr(2'd0, 16'hFFFF);
      look(2'd0); chk(reg_rdata == 16'h005F, "R2 cap low", 32'(reg_rdata), 32'h005F); #2;
      look(2'd1); chk(reg_rdata == 16'h012A, "R2 cap high", 32'(reg_rdata), 32'h012A); #2;
      // R5 completion timing
      wr(2'd2, 16'h017F);
      reg_addr = 2'd3;
      repeat (DLY - 1) @(negedge clk);
      chk(reg_rdata[4] == 1'b0, "R5 not yet", 32'(reg_rdata[4]), 32'h0);
      @(negedge clk);
      chk(reg_rdata[4] == 1'b1, "R5 completed", 32'(reg_rdata[4]), 32'h1);
      chk(irq == 1'b1, "R11 completion irq", 32'(irq), 32'h1); #2;
      chk(slot_pwr_en && attn_ind == 2'b01 && pwr_ind == 2'b01, "R3 power on",
          32'({slot_pwr_en, attn_ind, pwr_ind}), 32'h15);
      // R8 write of zeros keeps state, ones clear
      wr(2'd3, 16'h0000);
      look(2'd3); chk(reg_rdata[4] == 1'b1, "R8 zero write", 32'(reg_rdata[4]), 32'h1); #2;
      wr(2'd3, 16'h001F);
      look(2'd3); chk(reg_rdata[4:0] == 5'b0, "R8 clear all", 32'(reg_rdata[4:0]), 32'h0); #2;
      // R7 presence both edges
      present_in = 1'b1;
      look(2'd3); chk(reg_rdata[3] == 1'b1, "R7 presence rise", 32'(reg_rdata[3]), 32'h1); #2;
      chk(irq == 1'b1, "R11 presence irq", 32'(irq), 32'h1);
      wr(2'd3, 16'h0008);
      present_in = 1'b0;
      look(2'd3); chk(reg_rdata[3] == 1'b1, "R7 presence fall", 32'(reg_rdata[3]), 32'h1); #2;
      latch_in = 1'b1; step(1); latch_in = 1'b0;
      look(2'd3); chk(reg_rdata[2] == 1'b1, "R7 latch", 32'(reg_rdata[2]), 32'h1); #2;
      // R7 button rising only
      btn_in = 1'b1; step(2);
      wr(2'd3, 16'h0001);
      btn_in = 1'b0;
      look(2'd3); chk(reg_rdata[0] == 1'b0, "R7 button fall ignored", 32'(reg_rdata[0]), 32'h0); #2;
      wr(2'd3, 16'h001F);
      // R11 enables gate the interrupt
      present_in = 1'b1; step(1);
      wr(2'd2, 16'h0067);
      look(2'd3); chk(irq == 1'b0, "R11 masked event", 32'(irq), 32'h0); #2;
      step(DLY + 1);
      chk(irq == 1'b0, "R11 masked completion", 32'(irq), 32'h0);
      wr(2'd2, 16'h005F); step(DLY + 1);
      chk(irq == 1'b0, "R11 master off", 32'(irq), 32'h0);
      wr(2'd3, 16'h001F);
      // R9 sticky power fault while off
      wr(2'd2, 16'h047F);
      pfault_in = 1'b1; step(1); pfault_in = 1'b0;
      wr(2'd3, 16'h0002);
      look(2'd3); chk(reg_rdata[1] == 1'b1, "R9 held while off", 32'(reg_rdata[1]), 32'h1); #2;
      chk(!slot_pwr_en, "R3 power off", 32'(slot_pwr_en), 32'h0);
      wr(2'd2, 16'h007F);
      wr(2'd3, 16'h0002);
      look(2'd3); chk(reg_rdata[1] == 1'b0, "R9 cleared when on", 32'(reg_rdata[1]), 32'h0); #2;
      // R4 interlock toggle
      tog_count = 0;
      wr(2'd2, 16'h087F);
      step(3);
      chk(tog_count == 1, "R4 single pulse", 32'(tog_count), 32'h1);
      look(2'd2); chk(reg_rdata[11] == 1'b0, "R3 bit11 reads 0", 32'(reg_rdata[11]), 32'h0); #2;
      // R10 live levels
      ilock_state_in = 1'b1; latch_in = 1'b1; present_in = 1'b0;
      look(2'd3); chk(reg_rdata[15:5] == 11'b101, "R10 live bits", 32'(reg_rdata[15:5]), 32'h5); #2;
      step(DLY + 2);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      #(20 * 200000);
      errs++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule